// File: doc/BRIEF.md
# Synthesizer Programming Slave

This block is the serial-bus write front end of a frequency synthesizer. It watches a two-wire bus (clock line and data line, with an open-drain enable on the data line), oversampled by a fast system clock. It answers one 7-bit device address, whose two low bits come from a static select input. Every data byte that arrives in the same transaction is routed into one of three holding registers. These registers feed the synthesizer core: a 15-bit divider ratio, a 7-bit control word (pump current, test bits, reference ratio select, tuning-output disable) and an 8-bit port word.

Bytes arrive in pairs, and the top bit of the first byte of a pair picks its kind. A leading 0 opens a divider pair. The low seven bits of that byte are staged, and the divider register changes only when the second byte lands. A leading 1 is the control byte, which takes effect at once, and the byte after it is the port byte. A master may start with either kind of pair and may chain any number of pairs before STOP. A START or STOP condition in the middle of a pair drops whatever was staged.

The bus side is a link state machine with states LNK_IDLE, LNK_ADDR, LNK_ADDR_HIT, LNK_DATA, LNK_DATA_HIT, LNK_ACK, LNK_ACK_END and LNK_IGNORE:
- START moves any state to LNK_ADDR, and STOP moves any state to LNK_IDLE.
- The 8th rising clock edge moves LNK_ADDR to LNK_ADDR_HIT on a match, or to LNK_IGNORE otherwise, and moves LNK_DATA to LNK_DATA_HIT.
- A falling clock edge moves either HIT state to LNK_ACK.
- A rising clock edge moves LNK_ACK to LNK_ACK_END.
- A falling clock edge moves LNK_ACK_END to LNK_DATA.

The register side is a pair state machine with states PR_HEAD, PR_DIV_LO and PR_PORTS:
- A head byte with a leading 0 moves PR_HEAD to PR_DIV_LO.
- A head byte with a leading 1 moves PR_HEAD to PR_PORTS.
- Any completed byte returns PR_DIV_LO or PR_PORTS to PR_HEAD.
- START or STOP returns the machine to PR_HEAD.

Top module: `synth_prog_slave`

## Requirements
- R1: An address byte equal to 1,1,0,0,0,addr_sel[1],addr_sel[0] followed by a R/W bit of 0 is acknowledged. Any other address, or R/W = 1, gets no acknowledge, and the bytes that follow it before the next START neither acknowledge nor change any register.
- R2: After an acknowledged address, every data byte is acknowledged by driving sda_oe high while SCL is high in the 9th clock.
- R3: A head byte with bit 7 = 0 stages its bits 6:0 and leaves div_ratio unchanged. The next byte then sets div_ratio = {staged bits 6:0, byte bits 7:0}, which makes staged bit 6 the ratio's bit 14.
- R4: A head byte with bit 7 = 1 sets the control fields from its bits at the end of its 8th bit: cp_hi = bit 6, test_bits = bits 5:3, ref_sel = bits 2:1, tune_off = bit 0.
- R5: The byte following a control byte sets port_bits to that byte, with bit 3 forced to 0.
- R6: When a pair completes, the next byte is again a head byte whose bit 7 selects the pair kind, so several pairs may follow one address. At most one of the three registers changes per byte.
- R7: A START or STOP that arrives inside a pair discards the staged divider byte. The first data byte after the next address is treated as a head byte.
- R8: After reset div_ratio = 0, port_bits = 0, cp_hi = 0, test_bits = 3'b001, ref_sel = 0, tune_off = 0 and sda_oe = 0.
- R9: sda_oe rises only following a falling SCL edge (after the 8th bit). It falls following the next falling SCL edge (after the 9th), or following START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | When high, the pad pulls the data line low (acknowledge) |
| addr_sel | input | 2 | Static low address bits |
| div_ratio | output | 15 | Committed divider ratio |
| cp_hi | output | 1 | Charge-pump high-current select |
| test_bits | output | 3 | Test mode field |
| ref_sel | output | 2 | Reference divider ratio select |
| tune_off | output | 1 | Tuning output disable |
| port_bits | output | 8 | Committed port switch bits, bit 3 always 0 |

## Verification
The assertions assume a well-behaved master. SDA changes only while SCL is low, except to form START or STOP, and each SCL level lasts several system clocks beyond the synchronizer depth. Under those conditions an edge seen after synchronization is a true bus event, and the acknowledge enable is tied to the edges. The bench drives the bus through tasks whose quarter-bit phases last eight system clocks. It never changes SDA during a high SCL phase other than in its START and STOP tasks, and it models the wired line as the AND of its own drive and the inverted enable.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;

    // Bus-side link states
    typedef enum logic [2:0] {
        LNK_IDLE,
        LNK_ADDR,
        LNK_ADDR_HIT,
        LNK_DATA,
        LNK_DATA_HIT,
        LNK_ACK,
        LNK_ACK_END,
        LNK_IGNORE
    } link_state_t;

    // Register-side pair tracking
    typedef enum logic [1:0] {
        PR_HEAD,
        PR_DIV_LO,
        PR_PORTS
    } pair_state_t;

    typedef struct packed {
        logic       cp_hi;
        logic [2:0] test_bits;
        logic [1:0] ref_sel;
        logic       tune_off;
    } ctrl_word_t;

    localparam int         BYTE_W     = 8;
    localparam int         CTRL_W     = $bits(ctrl_word_t);
    localparam ctrl_word_t CTRL_RESET = '{cp_hi: 1'b0, test_bits: 3'b001,
                                          ref_sel: 2'b00, tune_off: 1'b0};

endpackage

// File: rtl/bus_line_sampler.sv
module bus_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] scl_q;
    logic [TOP:0] sda_q;
    logic         scl_p;
    logic         sda_p;
    logic         scl_s;

    // Synchronizer chains, idle-high reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q <= {scl_q[TOP-1:0], scl_i};
            sda_q <= {sda_q[TOP-1:0], sda_i};
            scl_p <= scl_q[TOP];
            sda_p <= sda_q[TOP];
        end
    end

    assign scl_s     = scl_q[TOP];
    assign sda_s     = sda_q[TOP];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    // Data edges while clock stays high mark frame boundaries
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/byte_link_fsm.sv
module byte_link_fsm
    import synth_prog_pkg::*;
#(
    parameter logic [4:0] ADDR_PREFIX = 5'b11000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [1:0]        addr_sel,
    output logic              sda_oe,
    output logic              byte_stb,
    output logic [BYTE_W-1:0] byte_data
);

    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    link_state_t       state_q, state_d;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-2:0] shreg;
    logic [BYTE_W-1:0] rx_word;
    logic              last_edge;
    logic              addr_ok;

    assign rx_word   = {shreg, sda_s};
    assign last_edge = scl_rise && (bit_cnt == LAST_BIT);
    assign addr_ok   = (rx_word == {ADDR_PREFIX, addr_sel, 1'b0});

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LNK_IDLE:     state_d = LNK_IDLE;
            LNK_ADDR:     if (last_edge) state_d = addr_ok ? LNK_ADDR_HIT : LNK_IGNORE;
            LNK_ADDR_HIT: if (scl_fall)  state_d = LNK_ACK;
            LNK_DATA:     if (last_edge) state_d = LNK_DATA_HIT;
            LNK_DATA_HIT: if (scl_fall)  state_d = LNK_ACK;
            LNK_ACK:      if (scl_rise)  state_d = LNK_ACK_END;
            LNK_ACK_END:  if (scl_fall)  state_d = LNK_DATA;
            LNK_IGNORE:   state_d = LNK_IGNORE;
        endcase
        if (start_det) begin
            state_d = LNK_ADDR;
        end else if (stop_det) begin
            state_d = LNK_IDLE;
        end
    end

    // State register with bit counter and shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LNK_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
        end else begin
            state_q <= state_d;
            if (start_det || state_q == LNK_ACK_END) begin
                bit_cnt <= '0;
            end else if (scl_rise && (state_q == LNK_ADDR || state_q == LNK_DATA)) begin
                bit_cnt <= bit_cnt + 1'b1;
                shreg   <= rx_word[BYTE_W-2:0];
            end
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe    <= 1'b0;
            byte_stb  <= 1'b0;
            byte_data <= '0;
        end else begin
            sda_oe   <= (state_d == LNK_ACK) || (state_d == LNK_ACK_END);
            byte_stb <= (state_q == LNK_DATA) && last_edge && !start_det && !stop_det;
            if ((state_q == LNK_DATA) && last_edge) begin
                byte_data <= rx_word;
            end
        end
    end

endmodule

// File: rtl/prog_reg_bank.sv
module prog_reg_bank
    import synth_prog_pkg::*;
#(
    parameter int PORT_DC_BIT = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_reset,
    input  logic                byte_stb,
    input  logic [BYTE_W-1:0]   byte_data,
    output logic [2*BYTE_W-2:0] div_ratio,
    output ctrl_word_t          ctrl_q,
    output logic [BYTE_W-1:0]   port_bits
);

    localparam int HI_W = BYTE_W - 1;

    pair_state_t       pair_q, pair_d;
    logic [HI_W-1:0]   stage_q;
    logic [BYTE_W-1:0] port_masked;
    logic              head_is_ctrl;

    assign head_is_ctrl = byte_data[BYTE_W-1];

    // Port byte with the unused bit cleared
    for (genvar i = 0; i < BYTE_W; i++) begin : g_port_mask
        if (i == PORT_DC_BIT) begin : g_dc
            assign port_masked[i] = 1'b0;
        end else begin : g_pass
            assign port_masked[i] = byte_data[i];
        end
    end

    always_comb begin
        pair_d = pair_q;
        if (frame_reset) begin
            pair_d = PR_HEAD;
        end else if (byte_stb) begin
            unique case (pair_q)
                PR_HEAD:   pair_d = head_is_ctrl ? PR_PORTS : PR_DIV_LO;
                PR_DIV_LO: pair_d = PR_HEAD;
                PR_PORTS:  pair_d = PR_HEAD;
                default:   pair_d = PR_HEAD;
            endcase
        end
    end

    // Pair state register and staging byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pair_q  <= PR_HEAD;
            stage_q <= '0;
        end else begin
            pair_q <= pair_d;
            if (frame_reset) begin
                stage_q <= '0;
            end else if (byte_stb && pair_q == PR_HEAD && !head_is_ctrl) begin
                stage_q <= byte_data[HI_W-1:0];
            end
        end
    end

    // Committed outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_ratio <= '0;
            ctrl_q    <= CTRL_RESET;
            port_bits <= '0;
        end else if (byte_stb && !frame_reset) begin
            unique case (pair_q)
                PR_HEAD:   if (head_is_ctrl) ctrl_q <= ctrl_word_t'(byte_data[CTRL_W-1:0]);
                PR_DIV_LO: div_ratio <= {stage_q, byte_data};
                PR_PORTS:  port_bits <= port_masked;
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/synth_prog_slave.sv
module synth_prog_slave
    import synth_prog_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [4:0] ADDR_PREFIX = 5'b11000,
    parameter int         PORT_DC_BIT = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe,
    input  logic [1:0]  addr_sel,
    output logic [14:0] div_ratio,
    output logic        cp_hi,
    output logic [2:0]  test_bits,
    output logic [1:0]  ref_sel,
    output logic        tune_off,
    output logic [7:0]  port_bits
);

    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              byte_stb;
    logic [BYTE_W-1:0] byte_data;
    ctrl_word_t        ctrl_q;

    bus_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) i_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    byte_link_fsm #(.ADDR_PREFIX(ADDR_PREFIX)) i_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .addr_sel  (addr_sel),
        .sda_oe    (sda_oe),
        .byte_stb  (byte_stb),
        .byte_data (byte_data)
    );

    prog_reg_bank #(.PORT_DC_BIT(PORT_DC_BIT)) i_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_reset (start_det | stop_det),
        .byte_stb    (byte_stb),
        .byte_data   (byte_data),
        .div_ratio   (div_ratio),
        .ctrl_q      (ctrl_q),
        .port_bits   (port_bits)
    );

    assign cp_hi     = ctrl_q.cp_hi;
    assign test_bits = ctrl_q.test_bits;
    assign ref_sel   = ctrl_q.ref_sel;
    assign tune_off  = ctrl_q.tune_off;

endmodule

// File: rtl/synth_prog_checker.sv
module synth_prog_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        scl_fall,
    input logic        start_det,
    input logic        stop_det,
    input logic        sda_oe,
    input logic        byte_stb,
    input logic [14:0] div_ratio,
    input logic [6:0]  ctrl_flat,
    input logic [7:0]  port_bits
);

    // Divider only moves one cycle after a completed data byte
    p_div_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_ratio) |-> $past(byte_stb));

    // Control word only moves after a completed data byte
    p_ctrl_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_flat) |-> $past(byte_stb));

    // Port word only moves after a completed data byte
    p_ports_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(port_bits) |-> $past(byte_stb));

    // One destination per byte
    p_single_dest_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!$stable(div_ratio), !$stable(ctrl_flat), !$stable(port_bits)}) <= 1);

    // Acknowledge starts right after a falling clock edge
    p_ack_begin_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall));

    // Acknowledge ends after a falling edge or a frame boundary
    p_ack_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> $past(scl_fall || start_det || stop_det));

    // A boundary always leaves the data line released
    p_boundary_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det || stop_det) |=> !sda_oe);

endmodule

bind synth_prog_slave synth_prog_checker i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .byte_stb  (byte_stb),
    .div_ratio (div_ratio),
    .ctrl_flat ({cp_hi, test_bits, ref_sel, tune_off}),
    .port_bits (port_bits)
);

// File: tb/test_synth_prog_slave.sv
module test_synth_prog_slave;

    localparam int QTR = 8;
    localparam logic [1:0] SEL = 2'b10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_drv = 1'b1;
    logic        sda_drv = 1'b1;
    logic [1:0]  addr_sel = SEL;
    logic        sda_line;
    logic        sda_oe;
    logic [14:0] div_ratio;
    logic        cp_hi;
    logic [2:0]  test_bits;
    logic [1:0]  ref_sel;
    logic        tune_off;
    logic [7:0]  port_bits;

    int checks = 0;
    int fails = 0;

    // Reference model state
    logic [14:0] m_div = '0;
    logic [6:0]  m_ctrl = 7'b0001000;
    logic [7:0]  m_ports = '0;
    logic [6:0]  m_stage = '0;
    int          m_phase = 0;
    logic [7:0]  txn_buf [8];

    always #10 clk = ~clk;

    assign sda_line = sda_drv & ~sda_oe;

    synth_prog_slave i_synth_prog_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_drv),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .addr_sel  (addr_sel),
        .div_ratio (div_ratio),
        .cp_hi     (cp_hi),
        .test_bits (test_bits),
        .ref_sel   (ref_sel),
        .tune_off  (tune_off),
        .port_bits (port_bits)
    );

    function automatic logic [14:0] div_word(input logic [6:0] hi, input logic [7:0] lo);
        return {hi, lo};
    endfunction

    function automatic logic [7:0] port_word(input logic [7:0] b);
        return b & 8'hF7;
    endfunction

    function automatic logic [7:0] addr_word(input logic [1:0] sel, input logic rw);
        return {5'b11000, sel, rw};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic qtr();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; qtr();
        scl_drv = 1'b1; qtr();
        sda_drv = 1'b0; qtr();
        scl_drv = 1'b0; qtr();
        m_phase = 0;
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; qtr();
        scl_drv = 1'b1; qtr();
        sda_drv = 1'b1; qtr(); qtr();
        m_phase = 0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i]; qtr();
            scl_drv = 1'b1; qtr(); qtr();
            scl_drv = 1'b0; qtr();
        end
        sda_drv = 1'b1; qtr();
        scl_drv = 1'b1; qtr();
        ack = sda_oe;
        qtr();
        scl_drv = 1'b0; qtr();
        chk("R9 enable released after 9th clock", sda_oe, 0);
    endtask

    task automatic model_byte(input logic [7:0] b);
        if (m_phase == 0) begin
            if (!b[7]) begin
                m_stage = b[6:0];
                m_phase = 1;
            end else begin
                m_ctrl  = b[6:0];
                m_phase = 2;
            end
        end else if (m_phase == 1) begin
            m_div   = div_word(m_stage, b);
            m_phase = 0;
        end else begin
            m_ports = port_word(b);
            m_phase = 0;
        end
    endtask

    task automatic check_regs(input string tag);
        chk({tag, " divider"}, div_ratio, m_div);
        chk({tag, " control"}, {cp_hi, test_bits, ref_sel, tune_off}, m_ctrl);
        chk({tag, " ports"}, port_bits, m_ports);
    endtask

    // Address byte, then n bytes of txn_buf; hit says whether acks are due
    task automatic run_bytes(input logic [7:0] adr, input logic hit, input int n);
        logic ack;
        send_byte(adr, ack);
        chk("R1 address acknowledge", ack, hit);
        for (int i = 0; i < n; i++) begin
            send_byte(txn_buf[i], ack);
            if (hit) begin
                chk("R2 data acknowledge", ack, 1);
                model_byte(txn_buf[i]);
            end else begin
                chk("R1 ignored byte no acknowledge", ack, 0);
            end
        end
    endtask

    initial begin
        logic ack;
        void'($urandom(32'h5A17));
        repeat (5) @(negedge clk);
        // R8 reset state
        chk("R8 reset divider", div_ratio, 0);
        chk("R8 reset control", {cp_hi, test_bits, ref_sel, tune_off}, 7'b0001000);
        chk("R8 reset ports", port_bits, 0);
        chk("R8 reset enable", sda_oe, 0);
        rst_n = 1'b1;
        qtr();

        // R3: divider holds until the second byte
        bus_start();
        send_byte(addr_word(SEL, 1'b0), ack);
        chk("R1 address acknowledge", ack, 1);
        send_byte(8'h2A, ack);
        model_byte(8'h2A);
        qtr();
        chk("R3 divider unchanged after first byte", div_ratio, 0);
        send_byte(8'h5C, ack);
        model_byte(8'h5C);
        qtr();
        chk("R3 divider after second byte", div_ratio, 15'h2A5C);
        // R4/R5 control then ports in the same frame (R6)
        send_byte(8'hCA, ack);
        model_byte(8'hCA);
        qtr();
        chk("R4 control fields", {cp_hi, test_bits, ref_sel, tune_off}, 7'h4A);
        send_byte(8'hFF, ack);
        model_byte(8'hFF);
        bus_stop();
        chk("R5 ports with bit 3 cleared", port_bits, 8'hF7);
        check_regs("R6 full frame");

        // R7: STOP inside a divider pair drops the staged byte
        bus_start();
        txn_buf[0] = 8'h05;
        run_bytes(addr_word(SEL, 1'b0), 1'b1, 1);
        bus_stop();
        bus_start();
        txn_buf[0] = 8'h9B;
        txn_buf[1] = 8'h0F;
        run_bytes(addr_word(SEL, 1'b0), 1'b1, 2);
        bus_stop();
        check_regs("R7 stop mid-pair");

        // R7: repeated START inside a pair
        bus_start();
        txn_buf[0] = 8'h11;
        run_bytes(addr_word(SEL, 1'b0), 1'b1, 1);
        bus_start();
        txn_buf[0] = 8'hC1;
        txn_buf[1] = 8'h20;
        txn_buf[2] = 8'h33;
        txn_buf[3] = 8'h44;
        run_bytes(addr_word(SEL, 1'b0), 1'b1, 4);
        bus_stop();
        check_regs("R7 repeated start mid-pair");

        // R1: wrong address and read request are ignored
        bus_start();
        txn_buf[0] = 8'h7F;
        txn_buf[1] = 8'hFF;
        run_bytes(addr_word(SEL ^ 2'b01, 1'b0), 1'b0, 2);
        bus_stop();
        check_regs("R1 wrong address ignored");
        bus_start();
        txn_buf[0] = 8'h80;
        txn_buf[1] = 8'h00;
        run_bytes(addr_word(SEL, 1'b1), 1'b0, 2);
        bus_stop();
        check_regs("R1 read request ignored");

        // Constrained random frames
        for (int t = 0; t < 24; t++) begin
            int kind;
            int n;
            kind = $urandom_range(0, 5);
            n    = $urandom_range(1, 7);
            for (int i = 0; i < n; i++) txn_buf[i] = 8'($urandom);
            bus_start();
            if (kind <= 3) begin
                run_bytes(addr_word(SEL, 1'b0), 1'b1, n);
            end else if (kind == 4) begin
                run_bytes(addr_word(SEL ^ 2'($urandom_range(1, 3)), 1'b0), 1'b0, n);
            end else begin
                run_bytes(addr_word(SEL, 1'b1), 1'b0, n);
            end
            bus_stop();
            check_regs("R6 random frame");
        end

        report();
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        report();
        $finish;
    end

endmodule